// File: doc/BRIEF.md
# Two-Level Warp Issue Scheduler

This block decides, every clock cycle, which group of threads (a warp) a SIMD core issues next and which quarter of that warp goes into the pipelined functional units. Threads are interleaved at two levels. Inside the chosen warp, a fixed sequence of sub-thread slots (0, 1, ..., SUB_SLOTS-1) goes out on consecutive cycles. Across warps, many warps stay resident, and the core moves to another one whenever the active warp finishes its slot sequence or can no longer proceed.

A warp can proceed only when two things hold: its ready input is high and its stall flag is clear. A stall request tagged with a warp number sets that warp's flag. It stays set until the pipeline or the memory side reports completion with the same tag. Warps are chosen round-robin, starting from the warp after the one most recently chosen, so no waiting warp is starved. When no warp can proceed, the scheduler emits a bubble and raises its idle output. Each thread waits longer as a result, but the core keeps busy while stalled warps wait out their latency.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `issue_valid` is 0 and `idle` is 1. All stall flags are clear, and the round-robin pointer points at warp NUM_WARPS-1, so the first warp chosen is the lowest eligible one.
- R2: A stall request (`stall_req_vld`, `stall_req_id`) sets the flag of that warp at the next clock edge. From that edge on, the warp is not eligible and is never issued while its flag is set.
- R3: A completion on `pipe_done_*` or on `mem_done_*` clears the flag of the tagged warp at the next edge. If a warp is set and cleared in the same cycle, it ends that cycle cleared.
- R4: Outputs are registered. A warp chosen in cycle n shows `issue_slot` = 0 in cycle n+1. While the warp stays eligible, it then shows slots 1, 2, ..., SUB_SLOTS-1 in the following cycles, with the same `issue_warp`.
- R5: If the active warp is no longer eligible before its last slot, the next cycle issues slot 0 of another eligible warp, or a bubble if there is none.
- R6: A new warp is chosen when the slot sequence ends or is cut short. The choice is the first eligible warp found going upward, modulo NUM_WARPS, starting after the warp chosen last. If the same warp is the only eligible one, it can be chosen again.
- R7: When no warp is eligible, the next cycle has `issue_valid` = 0 and `idle` = 1. The round-robin pointer keeps its value through idle cycles.
- R8: A warp whose `warp_ready` bit (bit index = warp number) is 0 is not eligible, whatever its stall flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready | input | NUM_WARPS | Bit w high: warp w has an instruction waiting |
| stall_req_vld | input | 1 | Stall request valid |
| stall_req_id | input | IDW | Warp to be marked stalled |
| pipe_done_vld | input | 1 | Pipeline completion valid |
| pipe_done_id | input | IDW | Warp whose pipeline result is available |
| mem_done_vld | input | 1 | Memory completion valid |
| mem_done_id | input | IDW | Warp whose memory result is available |
| issue_valid | output | 1 | A slot issues this cycle |
| issue_warp | output | IDW | Warp that issues |
| issue_slot | output | SLW | Sub-thread slot that issues |
| idle | output | 1 | Bubble: no warp was eligible |

## Verification
The bench runs an 8-warp, 4-slot configuration. It first checks targeted patterns: all warps ready, which shows the pure rotation and wraparound; two sparse ready warps, which shows that the search skips gaps; a stall raised in the middle of a slot sequence, which separates cutting the sequence short from finishing it; and set and clear in the same cycle on each completion port. It then sweeps all 256 ready masks, each held for several cycles, and follows with a long pseudo-random stretch of stall and completion traffic. At every cycle, an arithmetic model of eligibility and round-robin order predicts warp, slot and idle, so ordering faults and stall-flag faults each show up as a wrong warp at a specific cycle.

// File: rtl/wsch_pkg.sv
package wsch_pkg;

    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_HOLD   = 2'd1,
        PICK_SWITCH = 2'd2
    } pick_kind_e;

    function automatic int unsigned width_of(input int unsigned count);
        return (count <= 1) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/wsch_stall_table.sv
module wsch_stall_table #(
    parameter int unsigned NW  = 32,
    parameter int unsigned IDW = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           set_vld,
    input  logic [IDW-1:0] set_id,
    input  logic           pclr_vld,
    input  logic [IDW-1:0] pclr_id,
    input  logic           mclr_vld,
    input  logic [IDW-1:0] mclr_id,
    output logic [NW-1:0]  stall_q
);

    genvar w;
    generate
        for (w = 0; w < NW; w++) begin : g_flag
            logic hit_set, hit_clr;
            assign hit_set = set_vld && (set_id == IDW'(w));
            assign hit_clr = (pclr_vld && (pclr_id == IDW'(w))) ||
                             (mclr_vld && (mclr_id == IDW'(w)));
            always_ff @(posedge clk) begin
                if (rst)
                    stall_q[w] <= 1'b0;
                else if (hit_clr)
                    stall_q[w] <= 1'b0;
                else if (hit_set)
                    stall_q[w] <= 1'b1;
            end
        end
    endgenerate

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        (set_vld && (32'(set_id) < NW) &&
         !(pclr_vld && pclr_id == set_id) && !(mclr_vld && mclr_id == set_id))
        |=> stall_q[$past(set_id)])
        else $error("stall request did not set flag"); // R2
    AST_PIPE_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (pclr_vld && (32'(pclr_id) < NW)) |=> !stall_q[$past(pclr_id)])
        else $error("pipeline completion did not clear flag"); // R3
    AST_MEM_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (mclr_vld && (32'(mclr_id) < NW)) |=> !stall_q[$past(mclr_id)])
        else $error("memory completion did not clear flag"); // R3

endmodule

// File: rtl/wsch_rr_pick.sv
module wsch_rr_pick #(
    parameter int unsigned NW  = 32,
    parameter int unsigned IDW = 5
) (
    input  logic [NW-1:0]  elig,
    input  logic [IDW-1:0] base,
    output logic           any,
    output logic [IDW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = base;
        for (int off = 1; off <= int'(NW); off++) begin
            int cand;
            cand = (int'(base) + off) % int'(NW);
            if (!any && elig[cand]) begin
                any = 1'b1;
                idx = IDW'(cand);
            end
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wsch_pkg::*;
#(
    parameter int unsigned NUM_WARPS = 32,
    parameter int unsigned SUB_SLOTS = 4,
    localparam int unsigned IDW = width_of(NUM_WARPS),
    localparam int unsigned SLW = width_of(SUB_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] warp_ready,
    input  logic                 stall_req_vld,
    input  logic [IDW-1:0]       stall_req_id,
    input  logic                 pipe_done_vld,
    input  logic [IDW-1:0]       pipe_done_id,
    input  logic                 mem_done_vld,
    input  logic [IDW-1:0]       mem_done_id,
    output logic                 issue_valid,
    output logic [IDW-1:0]       issue_warp,
    output logic [SLW-1:0]       issue_slot,
    output logic                 idle
);

    localparam logic [SLW-1:0] LAST_SLOT = SLW'(SUB_SLOTS - 1);
    localparam logic [IDW-1:0] PTR_INIT  = IDW'(NUM_WARPS - 1);

    typedef struct packed {
        logic           vld;
        logic [IDW-1:0] warp;
        logic [SLW-1:0] slot;
    } issue_t;

    logic [NUM_WARPS-1:0] stall_q, elig, elig_q;
    logic                 pick_any;
    logic [IDW-1:0]       pick_idx, last_q;
    issue_t               iss_q, iss_d;
    pick_kind_e           kind;
    logic                 idle_q;

    wsch_stall_table #(.NW(NUM_WARPS), .IDW(IDW)) u_stall (
        .clk(clk), .rst(rst),
        .set_vld(stall_req_vld), .set_id(stall_req_id),
        .pclr_vld(pipe_done_vld), .pclr_id(pipe_done_id),
        .mclr_vld(mem_done_vld), .mclr_id(mem_done_id),
        .stall_q(stall_q)
    );

    assign elig = warp_ready & ~stall_q;

    wsch_rr_pick #(.NW(NUM_WARPS), .IDW(IDW)) u_pick (
        .elig(elig), .base(last_q), .any(pick_any), .idx(pick_idx)
    );

    always_comb begin
        if (iss_q.vld && iss_q.slot != LAST_SLOT && elig[iss_q.warp])
            kind = PICK_HOLD;
        else if (pick_any)
            kind = PICK_SWITCH;
        else
            kind = PICK_NONE;

        iss_d = '0;
        unique case (kind)
            PICK_HOLD:   iss_d = '{vld: 1'b1, warp: iss_q.warp, slot: iss_q.slot + 1'b1};
            PICK_SWITCH: iss_d = '{vld: 1'b1, warp: pick_idx, slot: '0};
            default:     iss_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_q  <= '0;
            last_q <= PTR_INIT;
            idle_q <= 1'b1;
            elig_q <= '0;
        end else begin
            iss_q  <= iss_d;
            idle_q <= (kind == PICK_NONE);
            elig_q <= elig;
            if (kind == PICK_SWITCH)
                last_q <= pick_idx;
        end
    end

    assign issue_valid = iss_q.vld;
    assign issue_warp  = iss_q.warp;
    assign issue_slot  = iss_q.slot;
    assign idle        = idle_q;

    AST_ISSUE_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !$past(rst)) |-> elig_q[issue_warp])
        else $error("issued a warp that was not eligible"); // R2
    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (rst)
        (idle && !$past(rst)) |-> (elig_q == '0))
        else $error("bubble while a warp was eligible"); // R7
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_slot != '0) |->
        ($past(issue_valid) && $past(issue_warp) == issue_warp &&
         issue_slot == SLW'($past(issue_slot) + 1'b1)))
        else $error("slot sequence broken"); // R4
    AST_HOLD_WHILE_OK: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_slot != LAST_SLOT && elig[issue_warp]) |=>
        (issue_valid && issue_warp == $past(issue_warp)))
        else $error("left an eligible warp mid-sequence"); // R4

endmodule

// File: tb/warp_issue_sched_bench.sv
`timescale 1ns/1ps
module warp_issue_sched_bench;

    localparam int NW = 8;
    localparam int NS = 4;
    localparam int IW = 3;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NW-1:0] warp_ready = '0;
    logic          stall_req_vld = 1'b0, pipe_done_vld = 1'b0, mem_done_vld = 1'b0;
    logic [IW-1:0] stall_req_id = '0, pipe_done_id = '0, mem_done_id = '0;
    logic          issue_valid, idle;
    logic [IW-1:0] issue_warp;
    logic [SW-1:0] issue_slot;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // model state
    bit m_stall [NW];
    bit m_vld, m_idle;
    int m_warp, m_slot, m_last;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #4 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .SUB_SLOTS(NS)) u_warp_issue_sched (
        .clk(clk), .rst(rst), .warp_ready(warp_ready),
        .stall_req_vld(stall_req_vld), .stall_req_id(stall_req_id),
        .pipe_done_vld(pipe_done_vld), .pipe_done_id(pipe_done_id),
        .mem_done_vld(mem_done_vld), .mem_done_id(mem_done_id),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_slot(issue_slot), .idle(idle)
    );

    task automatic check_out(input string tag);
        bit ok;
        ok = (issue_valid == m_vld) && (idle == m_idle) &&
             (!m_vld || (int'(issue_warp) == m_warp && int'(issue_slot) == m_slot));
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got vld=%0d warp=%0d slot=%0d idle=%0d exp vld=%0d warp=%0d slot=%0d idle=%0d",
                     tag, issue_valid, issue_warp, issue_slot, idle, m_vld, m_warp, m_slot, m_idle);
        end
    endtask

    // drive one cycle of inputs (called at negedge), predict, check at next negedge
    task automatic step(input string tag, input logic [NW-1:0] rdy,
                        input bit sv, input int sid, input bit pv, input int pid,
                        input bit mv, input int mid);
        bit el [NW];
        bit found;
        int pick;
        warp_ready = rdy;
        stall_req_vld = sv; stall_req_id = IW'(sid);
        pipe_done_vld = pv; pipe_done_id = IW'(pid);
        mem_done_vld  = mv; mem_done_id  = IW'(mid);
        for (int w = 0; w < NW; w++) el[w] = rdy[w] && !m_stall[w];
        found = 0; pick = 0;
        for (int off = 1; off <= NW; off++) begin
            int c;
            c = (m_last + off) % NW;
            if (!found && el[c]) begin found = 1; pick = c; end
        end
        if (m_vld && m_slot != NS - 1 && el[m_warp]) begin
            m_slot = m_slot + 1; m_idle = 0;
        end else if (found) begin
            m_vld = 1; m_warp = pick; m_slot = 0; m_last = pick; m_idle = 0;
        end else begin
            m_vld = 0; m_idle = 1;
        end
        for (int w = 0; w < NW; w++) begin
            if ((pv && pid == w) || (mv && mid == w)) m_stall[w] = 0;
            else if (sv && sid == w) m_stall[w] = 1;
        end
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic idle_step(input string tag, input logic [NW-1:0] rdy);
        step(tag, rdy, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NW; w++) m_stall[w] = 0;
        m_vld = 0; m_idle = 1; m_warp = 0; m_slot = 0; m_last = NW - 1;
        repeat (3) @(negedge clk);
        check_out("R1 in reset");
        warp_ready = '1;
        @(negedge clk);
        check_out("R1 during reset with ready");
        rst = 1'b0;
        check_out("R1 after release");

        // R4 / R6: all ready, pure rotation and wrap
        for (int i = 0; i < 40; i++) idle_step("R4 R6 all ready", '1);

        // R8: sparse ready
        for (int i = 0; i < 24; i++) idle_step("R8 sparse ready", 8'b0010_0100);

        // R5 / R2: stall active warp mid-sequence
        idle_step("R5 setup", 8'b0010_0100);
        step("R2 stall active", 8'b0010_0100, 1, m_warp, 0, 0, 0, 0);
        for (int i = 0; i < 10; i++) idle_step("R5 R2 after stall", 8'b0010_0100);

        // R3: clear via pipe, then same-cycle set+clear on mem
        step("R3 pipe clear", 8'b0010_0100, 0, 0, 1, 2, 0, 0);
        step("R3 pipe clear", 8'b0010_0100, 0, 0, 1, 5, 0, 0);
        for (int i = 0; i < 8; i++) idle_step("R3 both back", 8'b0010_0100);
        step("R3 set and mem clear same cycle", 8'b0000_1000, 1, 3, 0, 0, 1, 3);
        for (int i = 0; i < 6; i++) idle_step("R3 warp3 still issues", 8'b0000_1000);
        step("R3 set and pipe clear same cycle", 8'b0000_1000, 1, 3, 1, 3, 0, 0);
        for (int i = 0; i < 6; i++) idle_step("R3 warp3 again", 8'b0000_1000);

        // R7: nothing eligible, pointer held
        for (int i = 0; i < 5; i++) idle_step("R7 none ready", '0);
        step("R7 stall only ready warp", 8'b0000_0001, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) idle_step("R7 ready but stalled", 8'b0000_0001);
        step("R3 mem clear", 8'b1000_0001, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 12; i++) idle_step("R6 resume after idle", 8'b1000_0001);

        // R6 / R8: sweep all ready masks
        for (int m = 0; m < 256; m++)
            for (int k = 0; k < 5; k++) idle_step("R6 R8 mask sweep", NW'(m));

        // R2 R3 R5 R6: pseudo-random traffic
        for (int i = 0; i < 20000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R2 R3 R5 R6 random", lfsr[7:0] | lfsr[15:8],
                 lfsr[16], int'(lfsr[19:17]), lfsr[20] & lfsr[21], int'(lfsr[24:22]),
                 lfsr[25] & lfsr[26], int'(lfsr[29:27]));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule